// File: doc/BRIEF.md
# Sign-Correcting 8x8 Multiply Unit

The unit multiplies two 8-bit operands and places the 16-bit result in a product register pair, exposed as a high byte and a low byte. Every operation starts with one pass through an unsigned shift-add array. In unsigned mode that pass is the whole job, and the pair holds the final value after one clock. In signed mode a short sequencer then fixes the high byte so that the pair holds the two's-complement product. It first tests the sign of the second operand and conditionally subtracts the first operand. It then tests the sign of the first operand and conditionally subtracts the second operand.

A caller presents both operands and the mode select together with a one-cycle `start` pulse. The operands are captured at that edge. `busy` marks the cycles in which the correction sequence is still running, and `done` pulses once the pair is final. The unit has no data handshake. It accepts `start` only while idle and drops it silently while busy, so a caller that cannot wait must hold off until `busy` is low. No status flags are produced.

Top module: `mulseq_top`

## Requirements
- R1: In unsigned mode (`signed_mode`=0), `{prod_hi, prod_lo}` equals `op_a * op_b` taken as unsigned 8-bit numbers.
- R2: An unsigned start accepted at a clock edge makes the final product and `done`=1 visible right after that same edge, and `busy` stays 0.
- R3: In signed mode (`signed_mode`=1), the final `{prod_hi, prod_lo}` equals the 16-bit two's-complement product of `op_a` and `op_b` read as signed 8-bit numbers.
- R4: In signed mode, the edge that accepts the start loads the unsigned product. Two edges later the high byte becomes its previous value minus `op_a` (mod 256) if bit 7 of `op_b` is 1. Five edges after the start the high byte loses `op_b` (mod 256) if bit 7 of `op_a` is 1. The low byte keeps its unsigned value throughout.
- R5: A signed operation spans six cycles. `busy` is 1 for the five cycles after the start edge. The final product and `done`=1 appear after the fifth edge following the start edge, and at that point `busy` is 0.
- R6: The operands and mode are captured at the accepting edge, and changes on `op_a`, `op_b` or `signed_mode` during the sequence do not alter the result.
- R7: A `start` pulse while `busy` is 1 is ignored: neither the result nor the timing of the running operation changes.
- R8: `done` is a single-cycle pulse per operation, it is never 1 together with `busy`, and it is 0 in the cycle after the pulse unless a new start was accepted.
- R9: Reset (`rst_n`=0, asynchronous) clears `prod_hi`, `prod_lo`, `busy` and `done` to 0, also in the middle of a signed sequence.
- R10: While idle and without a start, the product pair holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; honoured only while idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| busy | output | 1 | Signed correction sequence in progress |
| done | output | 1 | One-cycle pulse: product pair is final |
| prod_hi | output | 8 | Product high byte |
| prod_lo | output | 8 | Product low byte |

## Verification
An unsigned result is due one edge after its start. A signed result is due five edges after its start. The first intermediate high byte follows the start edge, the second follows two edges later, and the busy window covers exactly the five cycles in between. The bench drives inputs and samples outputs on falling edges, and it counts those edges from each start, so every comparison falls in the cycle named by R2, R4 or R5. The unsigned sweep issues a new start every cycle, so each check sees the previous operand pair. The signed sweep scrambles the operand inputs and fires a spurious start mid-sequence, then checks the idle cycle that follows for a dropped `done` and a held product.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

  // Steps of the sign-correction sequence; IDLE also covers the unsigned path.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TEST_B = 3'd1,
    ST_SUB_A  = 3'd2,
    ST_LOAD_B = 3'd3,
    ST_TEST_A = 3'd4,
    ST_SUB_B  = 3'd5
  } step_t;

endpackage

// File: rtl/mulseq_array.sv
// Unsigned shift-add array: one row per multiplier bit, accumulated combinationally.
module mulseq_array #(
  parameter int W = 8
) (
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] product
);
  localparam int PW = 2 * W;

  logic [PW-1:0] acc [0:W];

  assign acc[0] = '0;

  for (genvar g = 0; g < W; g++) begin : g_row
    logic [PW-1:0] row;
    assign row        = mplier[g] ? ({{W{1'b0}}, mcand} << g) : '0;
    assign acc[g + 1] = acc[g] + row;
  end

  assign product = acc[W];

endmodule

// File: rtl/mulseq_fix.sv
// Conditional modulo-2^W subtraction applied to the product high byte.
module mulseq_fix #(
  parameter int W = 8
) (
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] subtrahend,
  input  logic         enable,
  output logic [W-1:0] hi_out
);
  always_comb begin
    if (enable) hi_out = hi_in - subtrahend;
    else        hi_out = hi_in;
  end
endmodule

// File: rtl/mulseq_ctrl.sv
// Sequencer: accepts a start while idle and walks the signed correction steps.
module mulseq_ctrl
  import mulseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  signed_mode,
  output step_t step,
  output logic  accept,
  output logic  busy,
  output logic  done
);
  step_t step_q, step_d;
  logic  done_q;

  assign accept = start && (step_q == ST_IDLE);

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE:   if (accept && signed_mode) step_d = ST_TEST_B;
      ST_TEST_B: step_d = ST_SUB_A;
      ST_SUB_A:  step_d = ST_LOAD_B;
      ST_LOAD_B: step_d = ST_TEST_A;
      ST_TEST_A: step_d = ST_SUB_B;
      ST_SUB_B:  step_d = ST_IDLE;
      default:   step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= (accept && !signed_mode) || (step_q == ST_SUB_B);
    end
  end

  assign step = step_q;
  assign busy = (step_q != ST_IDLE);
  assign done = done_q;

endmodule

// File: rtl/mulseq_top.sv
// Product register pair with sign-correcting sequence around one unsigned array.
module mulseq_top
  import mulseq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);
  localparam int PW = 2 * W;

  step_t          step;
  logic           accept;
  logic [W-1:0]   a_q, b_q;
  logic [W-1:0]   hi_q, lo_q;
  logic           sign_q;
  logic [PW-1:0]  raw_prod;
  logic [W-1:0]   sub_val;
  logic           sub_en;
  logic           hi_wr;
  logic [W-1:0]   hi_fixed;

  mulseq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .signed_mode (signed_mode),
    .step        (step),
    .accept      (accept),
    .busy        (busy),
    .done        (done)
  );

  // Array works on the live inputs so the unsigned result lands at the accepting edge.
  mulseq_array #(.W(W)) u_array (
    .mcand   (op_a),
    .mplier  (op_b),
    .product (raw_prod)
  );

  // One subtractor shared by both correction steps.
  assign hi_wr   = (step == ST_SUB_A) || (step == ST_SUB_B);
  assign sub_val = (step == ST_SUB_A) ? a_q : b_q;
  assign sub_en  = hi_wr && sign_q;

  mulseq_fix #(.W(W)) u_fix (
    .hi_in      (hi_q),
    .subtrahend (sub_val),
    .enable     (sub_en),
    .hi_out     (hi_fixed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      sign_q <= 1'b0;
    end else begin
      if (accept) begin
        a_q  <= op_a;
        b_q  <= op_b;
        hi_q <= raw_prod[PW-1:W];
        lo_q <= raw_prod[W-1:0];
      end else if (hi_wr) begin
        hi_q <= hi_fixed;
      end
      if (step == ST_TEST_B) sign_q <= b_q[W-1];
      if (step == ST_TEST_A) sign_q <= a_q[W-1];
    end
  end

  assign prod_hi = hi_q;
  assign prod_lo = lo_q;

endmodule

// File: rtl/mulseq_chk.sv
// Port-level checker; keeps its own shadow of the accepted operands.
module mulseq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         signed_mode,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] prod_hi,
  input logic [W-1:0] prod_lo
);
  localparam int PW = 2 * W;
  localparam int SPAN = 5;

  logic [W-1:0]  sh_a, sh_b;
  logic          sh_signed;
  logic [3:0]    busy_cnt;
  logic [PW-1:0] exp_u, exp_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_a      <= '0;
      sh_b      <= '0;
      sh_signed <= 1'b0;
      busy_cnt  <= '0;
    end else begin
      if (start && !busy) begin
        sh_a      <= op_a;
        sh_b      <= op_b;
        sh_signed <= signed_mode;
      end
      if (busy) busy_cnt <= busy_cnt + 4'd1;
      else      busy_cnt <= '0;
    end
  end

  assign exp_u = {{W{1'b0}}, sh_a} * {{W{1'b0}}, sh_b};
  assign exp_s = {{W{sh_a[W-1]}}, sh_a} * {{W{sh_b[W-1]}}, sh_b};

  AST_UNSIGNED_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !sh_signed |-> {prod_hi, prod_lo} == exp_u); // R1
  AST_UNSIGNED_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !signed_mode |=> done && !busy); // R2
  AST_SIGNED_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    done && sh_signed |-> {prod_hi, prod_lo} == exp_s); // R3
  AST_LOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(prod_lo)); // R4
  AST_SIGNED_ENTERS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && signed_mode |=> busy && !done); // R5
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_cnt < SPAN); // R5
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done && busy_cnt == SPAN); // R5
  AST_IGNORED_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> busy || done); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(prod_hi) && $stable(prod_lo) && !done); // R10

endmodule

bind mulseq_top mulseq_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .signed_mode (signed_mode),
  .op_a        (op_a),
  .op_b        (op_b),
  .busy        (busy),
  .done        (done),
  .prod_hi     (prod_hi),
  .prod_lo     (prod_lo)
);

// File: tb/sim_mulseq_top.sv
module sim_mulseq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       signed_mode = 1'b0;
  logic [7:0] op_a = '0;
  logic [7:0] op_b = '0;
  logic       busy, done;
  logic [7:0] prod_hi, prod_lo;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;
  logic [15:0] last_prod;
  logic        have_last = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mulseq_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
    .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] umul(input logic [7:0] a, input logic [7:0] b);
    return {8'h00, a} * {8'h00, b};
  endfunction

  function automatic logic [15:0] smul(input logic [7:0] a, input logic [7:0] b);
    return {{8{a[7]}}, a} * {{8{b[7]}}, b};
  endfunction

  // One signed operation with scrambled inputs and a spurious start mid-sequence.
  task automatic signed_op(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] u;
    logic [7:0]  hi1;
    u   = umul(a, b);
    hi1 = b[7] ? (u[15:8] - a) : u[15:8];
    @(negedge clk);
    if (have_last) begin
      chk("R8", "done after pulse", {31'd0, done}, 32'd0);
      chk("R10", "idle hold", {16'd0, prod_hi, prod_lo}, {16'd0, last_prod});
    end
    start = 1'b1; signed_mode = 1'b1; op_a = a; op_b = b;
    @(negedge clk);  // after start edge
    chk("R5", "busy after start", {31'd0, busy}, 32'd1);
    chk("R4", "unsigned step", {16'd0, prod_hi, prod_lo}, {16'd0, u});
    start = 1'b0; signed_mode = 1'b0; op_a = ~a; op_b = a ^ b;  // R6
    @(negedge clk);
    start = 1'b1; op_a = a + 8'd37;  // R7: ignored start
    @(negedge clk);  // after second edge: first correction
    start = 1'b0;
    chk("R4", "first correction", {24'd0, prod_hi}, {24'd0, hi1});
    chk("R4", "low kept", {24'd0, prod_lo}, {24'd0, u[7:0]});
    @(negedge clk);
    @(negedge clk);
    chk("R5", "busy before last", {30'd0, busy, done}, 32'd2);
    @(negedge clk);  // after fifth edge
    chk("R5", "done, not busy", {30'd0, busy, done}, 32'd1);
    chk("R3", "signed product", {16'd0, prod_hi, prod_lo}, {16'd0, smul(a, b)});
    last_prod = smul(a, b);
    have_last = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    chk("R9", "reset outputs", {14'd0, busy, done, prod_hi, prod_lo}, 32'd0);
    rst_n = 1'b1;

    // R1/R2: exhaustive unsigned sweep, one start per cycle
    for (int i = 0; i <= 65536; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R1", "unsigned product", {16'd0, prod_hi, prod_lo}, {16'd0, last_prod});
        chk("R2", "done/busy", {30'd0, busy, done}, 32'd1);
      end
      if (i < 65536) begin
        start = 1'b1; signed_mode = 1'b0;
        op_a = i[15:8]; op_b = i[7:0];
        last_prod = umul(i[15:8], i[7:0]);
      end else begin
        start = 1'b0;
      end
    end
    have_last = 1'b1;

    // R3-R8: signed sweep, all op_a against 32 op_b values incl. 00,7F,80,FF
    for (int j = 0; j < 32; j++) begin
      for (int k = 0; k < 256; k++) begin
        logic [4:0] jj;
        jj = j[4:0];
        signed_op(k[7:0], {jj, 3'b000} | {5'b00000, jj[2:0]});
      end
    end

    // R9: reset in the middle of a signed sequence
    @(negedge clk);
    start = 1'b1; signed_mode = 1'b1; op_a = 8'h80; op_b = 8'h80;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9", "mid-op reset", {14'd0, busy, done, prod_hi, prod_lo}, 32'd0);
    rst_n = 1'b1;
    have_last = 1'b0;
    signed_op(8'h80, 8'h80);  // R3: expect 4000
    chk("R3", "corner 80*80", {16'd0, prod_hi, prod_lo}, 32'h4000);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule